// File: doc/BRIEF.md
# Two-Bus Register Datapath with Bus Tie

This block is the data section of a small processor core. Eight general registers and one operand register sit between two internal buses. Each register drives the source bus (bus A) when its read strobe is high. Each register loads from the destination bus (bus B) on a rising clock edge when its write strobe is high. Bus A also feeds the first ALU input. The operand register Y holds the second ALU input.

Bus B has only three possible sources: a tie gate that copies bus A across, the ALU result, or nothing (zero). Because the ALU result goes straight onto bus B, no result register is needed. A three-operand add such as R3 = R1 + R2 therefore takes two steps. In the first step, R1 crosses the tie into Y. In the second step, R2 is put on bus A while the ALU adds and R3 loads the sum.

An external data port can also drive bus A, so that values enter the datapath through the tie. A sequencer drives every strobe once per cycle, and the block cannot stall. For this reason the edge carries no valid/ready handshake: a strobe that is high in a cycle takes effect at the end of that cycle, and no back-pressure exists. Illegal strobe combinations raise an error pin.

Top module: `twobus_dp`

## Requirements
- R1: After reset, all eight general registers and Y hold zero.
- R2: Bus A carries the value of its single active source. That source is a register whose read strobe is high, or `ext_data` when `ext_drive` is high. With no source, bus A is zero.
- R3: With `tie_en` high and no error, bus B equals bus A. With both `tie_en` and `alu_drive` low, bus B is zero, so the buses are isolated.
- R4: A general register whose write strobe is high loads bus B on the rising edge. Registers whose write strobe is low keep their value.
- R5: When `y_load` is high, Y loads bus B on the rising edge. Otherwise Y holds its value.
- R6: With `alu_drive` high and no error, bus B carries the ALU result of bus A (first operand) and Y (second operand). `alu_op` selects the operation: 0 is add, 1 is subtract, 2 is AND, 3 is OR.
- R7: Add computes A + Y + `carry_in`. Flag carry is the carry out of bit 15. Flag overflow is set when both operands share a sign and the result's sign differs.
- R8: Subtract computes A − Y and ignores `carry_in`. Flag carry is 1 when no borrow occurs (A ≥ Y, unsigned). Flag overflow is set when the operand signs differ and the result's sign differs from A.
- R9: `alu_flags` is {carry, zero, negative, overflow}, from bit 3 down to bit 0. Zero means the result is all zeros, and negative is result bit 15. For AND and OR, carry and overflow are 0.
- R10: `bus_err` goes high, and bus B is forced to zero, in any of three cases: more than one bus A source is active, `tie_en` and `alu_drive` are both high, or a register's read and write strobes are high together. Any load made in that cycle stores zero.
- R11: The two-step sequence loads the sum of R1 and R2 into R3. Step one is R1 read, tie, Y load. Step two is R2 read, add, ALU drive, R3 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 8 | Per-register read strobes onto bus A |
| dst_sel | input | 8 | Per-register write strobes from bus B |
| ext_drive | input | 1 | Puts ext_data on bus A |
| ext_data | input | 16 | External value for bus A |
| tie_en | input | 1 | Bus tie gate, copies bus A to bus B |
| y_load | input | 1 | Loads Y from bus B |
| alu_drive | input | 1 | Puts ALU result on bus B |
| alu_op | input | 2 | ALU operation: 0 add, 1 sub, 2 AND, 3 OR |
| carry_in | input | 1 | Carry input for add |
| bus_a | output | 16 | Source bus value |
| bus_b | output | 16 | Destination bus value |
| alu_flags | output | 4 | {carry, zero, negative, overflow} |
| bus_err | output | 1 | Illegal strobe combination |

## Verification
Ten operand pairs are loaded through the tie. Each pair then goes through Y and the ALU into R3, and is read back from R3. Add is tried plain, with a carry-in, with a wrap to zero, and with a signed overflow in each direction. Subtract is tried with a borrow, a signed overflow and an equal-operand zero, which separates the carry sense from the overflow sense. AND and OR are tried with patterns that set zero or negative. Separate directed steps set up each of the three error causes on its own, so the bench can tell them apart. The same steps show the buses isolated with the tie off, and show a bystander register holding its value across all this traffic.

// File: rtl/twobus_pkg.sv
package twobus_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_OR  = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic carry;
    logic zero;
    logic neg;
    logic ovf;
  } alu_flags_t;
endpackage

// File: rtl/twobus_alu.sv
module twobus_alu
  import twobus_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  input  logic         cin,
  output logic [W-1:0] res,
  output alu_flags_t   flags
);
  logic [W:0] sum;

  always_comb begin
    sum = '0;
    res = '0;
    flags = '0;
    unique case (op)
      OP_ADD: begin
        sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        res = sum[W-1:0];
        flags.carry = sum[W];
        flags.ovf = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
      end
      OP_SUB: begin
        sum = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
        res = sum[W-1:0];
        flags.carry = sum[W];
        flags.ovf = (a[W-1] != b[W-1]) && (res[W-1] != a[W-1]);
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      default: res = '0;
    endcase
    flags.zero = (res == '0);
    flags.neg = res[W-1];
  end
endmodule

// File: rtl/twobus_regfile.sv
module twobus_regfile #(
  parameter int NREG = 8,
  parameter int W    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] src_sel,
  input  logic [NREG-1:0] dst_sel,
  input  logic [W-1:0]    wr_data,
  output logic [W-1:0]    rd_val,
  output logic [W-1:0]    reg_q [NREG]
);
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          reg_q[k] <= '0;
      else if (dst_sel[k]) reg_q[k] <= wr_data;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NREG; k++) begin
      if (src_sel[k]) rd_val = rd_val | reg_q[k];
    end
  end
endmodule

// File: rtl/twobus_busctl.sv
module twobus_busctl #(
  parameter int NREG = 8,
  parameter int W    = 16
) (
  input  logic [NREG-1:0] src_sel,
  input  logic [NREG-1:0] dst_sel,
  input  logic            ext_drive,
  input  logic [W-1:0]    ext_data,
  input  logic            tie_en,
  input  logic            alu_drive,
  input  logic [W-1:0]    rd_val,
  input  logic [W-1:0]    alu_res,
  output logic [W-1:0]    bus_a,
  output logic [W-1:0]    bus_b,
  output logic            bus_err
);
  logic multi_src, tie_alu, rw_same;

  always_comb begin
    multi_src = ($countones({src_sel, ext_drive}) > 1);
    tie_alu   = tie_en && alu_drive;
    rw_same   = |(src_sel & dst_sel);
    bus_err   = multi_src || tie_alu || rw_same;
    bus_a     = multi_src ? '0 : (rd_val | (ext_drive ? ext_data : '0));
    if (bus_err)        bus_b = '0;
    else if (tie_en)    bus_b = bus_a;
    else if (alu_drive) bus_b = alu_res;
    else                bus_b = '0;
  end
endmodule

// File: rtl/twobus_dp.sv
module twobus_dp
  import twobus_pkg::*;
#(
  parameter int NREG = 8,
  parameter int W    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] src_sel,
  input  logic [NREG-1:0] dst_sel,
  input  logic            ext_drive,
  input  logic [W-1:0]    ext_data,
  input  logic            tie_en,
  input  logic            y_load,
  input  logic            alu_drive,
  input  logic [1:0]      alu_op,
  input  logic            carry_in,
  output logic [W-1:0]    bus_a,
  output logic [W-1:0]    bus_b,
  output logic [3:0]      alu_flags,
  output logic            bus_err
);
  logic [W-1:0] rd_val;
  logic [W-1:0] reg_q [NREG];
  logic [W-1:0] y_q;
  logic [W-1:0] alu_res;
  alu_flags_t   flg;

  twobus_regfile #(.NREG(NREG), .W(W)) u_rf (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .dst_sel(dst_sel),
    .wr_data(bus_b), .rd_val(rd_val), .reg_q(reg_q)
  );

  twobus_busctl #(.NREG(NREG), .W(W)) u_bc (
    .src_sel(src_sel), .dst_sel(dst_sel), .ext_drive(ext_drive),
    .ext_data(ext_data), .tie_en(tie_en), .alu_drive(alu_drive),
    .rd_val(rd_val), .alu_res(alu_res), .bus_a(bus_a), .bus_b(bus_b),
    .bus_err(bus_err)
  );

  twobus_alu #(.W(W)) u_alu (
    .a(bus_a), .b(y_q), .op(alu_op_e'(alu_op)), .cin(carry_in),
    .res(alu_res), .flags(flg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      y_q <= '0;
    else if (y_load) y_q <= bus_b;
  end

  assign alu_flags = flg;
endmodule

// File: rtl/twobus_dp_chk.sv
module twobus_dp_chk #(
  parameter int NREG = 8,
  parameter int W    = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREG-1:0] src_sel,
  input logic [NREG-1:0] dst_sel,
  input logic            ext_drive,
  input logic            tie_en,
  input logic            y_load,
  input logic            alu_drive,
  input logic [W-1:0]    bus_a,
  input logic [W-1:0]    bus_b,
  input logic            bus_err,
  input logic [W-1:0]    reg_q [NREG],
  input logic [W-1:0]    y_q
);
  // R3
  tie_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tie_en && !bus_err) |-> (bus_b == bus_a));

  // R3
  isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tie_en && !alu_drive) |-> (bus_b == '0));

  // R10
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_b == '0));

  // R10
  multi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({src_sel, ext_drive}) > 1) |-> bus_err);

  // R5
  y_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_load |=> (y_q == $past(bus_b)));

  // R5
  y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !y_load |=> $stable(y_q));

  for (genvar k = 0; k < NREG; k++) begin : g_chk
    // R4
    reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dst_sel[k] |=> (reg_q[k] == $past(bus_b)));

    // R4
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dst_sel[k] |=> $stable(reg_q[k]));
  end
endmodule

bind twobus_dp twobus_dp_chk #(.NREG(NREG), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .dst_sel(dst_sel),
  .ext_drive(ext_drive), .tie_en(tie_en), .y_load(y_load),
  .alu_drive(alu_drive), .bus_a(bus_a), .bus_b(bus_b), .bus_err(bus_err),
  .reg_q(reg_q), .y_q(y_q)
);

// File: tb/tb_twobus_dp.sv
module tb_twobus_dp;
  localparam int NREG = 8;
  localparam int W    = 16;

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic [1:0]  op;
    logic        ci;
    logic [15:0] r;
    logic [3:0]  f;
  } vec_t;

  // flags {carry, zero, negative, overflow}; op 0 add 1 sub 2 and 3 or
  localparam vec_t VEC [10] = '{
    '{16'h0001, 16'h0002, 2'd0, 1'b0, 16'h0003, 4'b0000},
    '{16'hFFFF, 16'h0001, 2'd0, 1'b0, 16'h0000, 4'b1100},
    '{16'h7FFF, 16'h0000, 2'd0, 1'b1, 16'h8000, 4'b0011},
    '{16'h0005, 16'h0007, 2'd1, 1'b0, 16'hFFFE, 4'b0010},
    '{16'h8000, 16'h0001, 2'd1, 1'b0, 16'h7FFF, 4'b1001},
    '{16'h1234, 16'h1234, 2'd1, 1'b1, 16'h0000, 4'b1100},
    '{16'hF0F0, 16'h0FF0, 2'd2, 1'b0, 16'h00F0, 4'b0000},
    '{16'h8000, 16'h0001, 2'd3, 1'b0, 16'h8001, 4'b0010},
    '{16'h00FF, 16'hFF00, 2'd2, 1'b1, 16'h0000, 4'b0100},
    '{16'h8000, 16'h8000, 2'd0, 1'b0, 16'h0000, 4'b1101}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NREG-1:0] src_sel = '0;
  logic [NREG-1:0] dst_sel = '0;
  logic            ext_drive = 1'b0;
  logic [W-1:0]    ext_data = '0;
  logic            tie_en = 1'b0;
  logic            y_load = 1'b0;
  logic            alu_drive = 1'b0;
  logic [1:0]      alu_op = '0;
  logic            carry_in = 1'b0;
  logic [W-1:0]    bus_a, bus_b;
  logic [3:0]      alu_flags;
  logic            bus_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  twobus_dp #(.NREG(NREG), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .dst_sel(dst_sel),
    .ext_drive(ext_drive), .ext_data(ext_data), .tie_en(tie_en),
    .y_load(y_load), .alu_drive(alu_drive), .alu_op(alu_op),
    .carry_in(carry_in), .bus_a(bus_a), .bus_b(bus_b),
    .alu_flags(alu_flags), .bus_err(bus_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // applies one step of strobes after a falling edge, settles 1 ns
  task automatic drv(input logic [NREG-1:0] so, input logic [NREG-1:0] di,
                     input logic ed, input logic [W-1:0] d, input logic t,
                     input logic yl, input logic ad, input logic [1:0] op,
                     input logic ci);
    @(negedge clk);
    src_sel = so; dst_sel = di; ext_drive = ed; ext_data = d;
    tie_en = t; y_load = yl; alu_drive = ad; alu_op = op; carry_in = ci;
    #1;
  endtask

  task automatic idle();
    drv('0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic put(input int k, input logic [W-1:0] v);
    drv('0, NREG'(1) << k, 1'b1, v, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic read_reg(input int k, output logic [W-1:0] v);
    drv(NREG'(1) << k, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    v = bus_a;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every register reads zero after reset
    for (int k = 0; k < NREG; k++) begin
      read_reg(k, v);
      check("R1 reg after reset", 32'(v), 32'h0);
    end
    // R1: Y zero -> add with empty bus A gives zero
    drv('0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0);
    check("R1 Y after reset", 32'(bus_b), 32'h0);
    // R2: no source means bus A is zero
    idle();
    check("R2 bus A idle", 32'(bus_a), 32'h0);
    // R2: external source on bus A
    drv('0, '0, 1'b1, 16'h3C3C, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    check("R2 ext on bus A", 32'(bus_a), 32'h3C3C);
    // R3: tie off and no ALU isolates bus B
    check("R3 isolated bus B", 32'(bus_b), 32'h0);

    // bystander for R4 hold
    put(4, 16'hBEEF);

    // vector loop: R6 R7 R8 R9 and R4 load
    for (int i = 0; i < 10; i++) begin
      put(1, VEC[i].a);
      put(2, VEC[i].b);
      drv(8'h04, '0, 1'b0, '0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0);
      check("R3 tie passes bus A", 32'(bus_b), 32'(VEC[i].b));
      drv(8'h02, 8'h08, 1'b0, '0, 1'b0, 1'b0, 1'b1, VEC[i].op, VEC[i].ci);
      check("R6 R7 R8 ALU result on bus B", 32'(bus_b), 32'(VEC[i].r));
      check("R9 flags", 32'(alu_flags), 32'(VEC[i].f));
      check("R10 no error", 32'(bus_err), 32'h0);
      read_reg(3, v);
      check("R4 R3 register loaded", 32'(v), 32'(VEC[i].r));
    end

    read_reg(4, v);
    check("R4 bystander holds", 32'(v), 32'hBEEF);

    // R11: R3 = R1 + R2 in two steps
    put(1, 16'h0100);
    put(2, 16'h0023);
    drv(8'h02, '0, 1'b0, '0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0);
    drv(8'h04, 8'h08, 1'b0, '0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0);
    read_reg(3, v);
    check("R11 two-step add", 32'(v), 32'h0123);

    // R10: two register sources
    drv(8'h06, '0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
    check("R10 multi source err", 32'(bus_err), 32'h1);
    check("R10 multi source bus B", 32'(bus_b), 32'h0);
    // R10: register plus external source
    drv(8'h02, '0, 1'b1, 16'h1111, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
    check("R10 reg plus ext err", 32'(bus_err), 32'h1);
    // R10: tie and ALU together
    drv(8'h02, '0, 1'b0, '0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0);
    check("R10 tie plus alu err", 32'(bus_err), 32'h1);
    check("R10 tie plus alu bus B", 32'(bus_b), 32'h0);
    // R10: same register read and written loads zero
    put(5, 16'h5A5A);
    drv(8'h20, 8'h20, 1'b0, '0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
    check("R10 read write same err", 32'(bus_err), 32'h1);
    read_reg(5, v);
    check("R10 conflicting load stores zero", 32'(v), 32'h0);
    idle();
    check("R10 error clears", 32'(bus_err), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule